// File: doc/BRIEF.md
# MSI Capture Ring Writer

This block turns incoming message-signalled interrupt writes into entries of a ring that lives in system memory. Each accepted message is formatted as a 16-byte entry and sent out on a memory-write request port. The address of that request is a programmable 64-bit base plus the block's own write offset. After the memory side takes the entry, the write offset moves forward by one entry and wraps at the end of the ring. The ring size is selectable as a power of two between 32 KB and 256 KB.

Host software owns the read offset. It writes that offset through the register port as it drains entries, and it can read the write offset at any time. A level interrupt stays high while the ring holds unread entries. When the ring is full, the block either holds the next message off through the input handshake or drops it and sets a sticky overflow flag. A control bit picks which.

Top module: `msi_ring_writer`

## Requirements
- R1: After reset every register reads as zero, `irq` is low and `mem_valid` is low.
- R2: Register word addresses are 0 control, 3 base address upper 32 bits, 4 base address lower 32 bits, 5 read offset and 6 write offset. Control bit 0 is run, bit 1 is full-check, bit 3 is interrupt enable, bit 4 is stop-on-full, bits 9:8 are size select and bit 16 is the overflow flag. The run, full-check, interrupt-enable, stop-on-full and size-select fields read back as written. Writes to address 6 are ignored, and all other addresses read zero.
- R3: A value written to the read offset is ANDed with (2^(15+k) - 1) and its low four bits are cleared, where k is the current size select.
- R4: An issued entry has `mem_addr` = base + write offset. Bits 15:0 of `mem_data` hold bits 15:0 of the message word (byte 0 of the entry is bits 7:0), and bits 127:16 are zero.
- R5: `mem_valid`, `mem_addr` and `mem_data` stay constant until `mem_ready` is high. While an entry is outstanding, `msg_ready` is low.
- R6: The write offset increases by 16 only in the cycle after a `mem_valid`/`mem_ready` handshake. It wraps to zero at 2^(15+k) bytes.
- R7: While run is clear, messages are accepted (`msg_ready` high) and discarded. No memory write is issued and the write offset does not change.
- R8: The ring is full when write offset + 16, wrapped, equals the read offset. With run, full-check and stop-on-full all set and the ring full, `msg_ready` stays low.
- R9: With run and full-check set, stop-on-full clear and the ring full, a message is accepted and dropped, and control bit 16 becomes 1. The bit stays 1 until a control write with bit 16 set clears it.
- R10: With full-check clear, no full detection takes place. The entry is written and the write offset may become equal to the read offset.
- R11: `irq` is high exactly when run and interrupt enable are set and the write offset differs from the read offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register word address |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| msg_valid | input | 1 | Incoming message present |
| msg_ready | output | 1 | Block can take the message this cycle |
| msg_data | input | 32 | Message data word (interrupt number in bits 15:0) |
| mem_valid | output | 1 | Memory write request pending |
| mem_ready | input | 1 | Memory side accepts the request |
| mem_addr | output | 64 | Byte address of the entry |
| mem_data | output | 128 | Entry contents |
| irq | output | 1 | Level interrupt: unread entries pending |

## Verification
The ring is driven with random message words and random memory-accept latencies. These separate a correct entry layout and address from values that are latched too late or change before acceptance. A full fill of the smallest ring against a fixed read offset exercises the wrap and then the full condition. The same full ring is then met in turn under stall, drop and no-check settings, which separates the three ways a full ring is handled. A random mix of read-offset writes and control changes, followed by a complete lap of the 64 KB ring, checks the masking, the interrupt level and the wrap point for a second size.

// File: rtl/msi_ring_pkg.sv
`timescale 1ns/1ps
package msi_ring_pkg;
    localparam int REG_W      = 32;
    localparam int REG_AW     = 3;
    localparam int BASE_W     = 2 * REG_W;
    localparam int SEL_W      = 2;
    localparam int MIN_LOG2   = 15;
    localparam int OFF_W      = MIN_LOG2 + (1 << SEL_W) - 1;
    localparam int ENT_LOG2   = 4;
    localparam int ENT_BYTES  = 1 << ENT_LOG2;
    localparam int DATA_W     = 8 * ENT_BYTES;
    localparam int NUM_W      = 16;

    localparam int CB_RUN     = 0;
    localparam int CB_FULLCHK = 1;
    localparam int CB_IRQ     = 3;
    localparam int CB_STOP    = 4;
    localparam int CB_SEL     = 8;
    localparam int CB_OVF     = 16;

    typedef enum logic [REG_AW-1:0] {
        RA_CTRL    = 3'd0,
        RA_BASE_HI = 3'd3,
        RA_BASE_LO = 3'd4,
        RA_RDOFF   = 3'd5,
        RA_WROFF   = 3'd6
    } reg_addr_e;

    typedef struct packed {
        logic             run;
        logic             full_chk;
        logic             irq_on;
        logic             stop_full;
        logic [SEL_W-1:0] size_sel;
    } ring_cfg_t;

    typedef enum logic {ST_IDLE, ST_BUSY} wr_state_e;

    function automatic logic [OFF_W-1:0] ring_mask(input logic [SEL_W-1:0] sel);
        logic [OFF_W:0] lim;
        lim = (OFF_W+1)'(1) << (MIN_LOG2 + int'(sel));
        return OFF_W'(lim - 1'b1) & ~OFF_W'(ENT_BYTES - 1);
    endfunction

    function automatic logic [DATA_W-1:0] make_entry(input logic [NUM_W-1:0] num);
        return {{(DATA_W-NUM_W){1'b0}}, num};
    endfunction
endpackage

// File: rtl/msi_ring_regs.sv
`timescale 1ns/1ps
module msi_ring_regs
    import msi_ring_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wen,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic              ovf_set,
    output ring_cfg_t         cfg,
    output logic [BASE_W-1:0] base,
    output logic [OFF_W-1:0]  rd_off
);
    logic [REG_W-1:0] base_hi, base_lo;
    logic             ovf_q;
    logic             ctrl_wr, ovf_clr;

    assign ctrl_wr = reg_wen && (reg_addr == RA_CTRL);
    assign ovf_clr = ctrl_wr && reg_wdata[CB_OVF];
    assign base    = {base_hi, base_lo};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg     <= '0;
            base_hi <= '0;
            base_lo <= '0;
            rd_off  <= '0;
        end else if (reg_wen) begin
            case (reg_addr)
                RA_CTRL: begin
                    cfg.run       <= reg_wdata[CB_RUN];
                    cfg.full_chk  <= reg_wdata[CB_FULLCHK];
                    cfg.irq_on    <= reg_wdata[CB_IRQ];
                    cfg.stop_full <= reg_wdata[CB_STOP];
                    cfg.size_sel  <= reg_wdata[CB_SEL +: SEL_W];
                end
                RA_BASE_HI: base_hi <= reg_wdata;
                RA_BASE_LO: base_lo <= reg_wdata;
                RA_RDOFF:   rd_off  <= reg_wdata[OFF_W-1:0] & ring_mask(cfg.size_sel);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          ovf_q <= 1'b0;
        else if (ovf_set) ovf_q <= 1'b1;
        else if (ovf_clr) ovf_q <= 1'b0;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CTRL: begin
                reg_rdata[CB_RUN]            = cfg.run;
                reg_rdata[CB_FULLCHK]        = cfg.full_chk;
                reg_rdata[CB_IRQ]            = cfg.irq_on;
                reg_rdata[CB_STOP]           = cfg.stop_full;
                reg_rdata[CB_SEL +: SEL_W]   = cfg.size_sel;
                reg_rdata[CB_OVF]            = ovf_q;
            end
            RA_BASE_HI: reg_rdata = base_hi;
            RA_BASE_LO: reg_rdata = base_lo;
            RA_RDOFF:   reg_rdata = REG_W'(rd_off);
            RA_WROFF:   reg_rdata = REG_W'(wr_off);
            default:    reg_rdata = '0;
        endcase
    end

    // R3: read offset always entry aligned
    a_r3_rdoff_aligned: assert property (@(posedge clk) disable iff (rst)
        rd_off[ENT_LOG2-1:0] == '0);

    // R9: overflow flag stays set until an explicit clear
    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        $past(ovf_q) && !$past(ovf_clr) |-> ovf_q);
endmodule

// File: rtl/msi_ring_ctrl.sv
`timescale 1ns/1ps
module msi_ring_ctrl
    import msi_ring_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ring_cfg_t         cfg,
    input  logic [BASE_W-1:0] base,
    input  logic [OFF_W-1:0]  rd_off,
    input  logic              msg_valid,
    output logic              msg_ready,
    input  logic [REG_W-1:0]  msg_data,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [BASE_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic [OFF_W-1:0]  wr_off,
    output logic              ovf_set,
    output logic              irq
);
    wr_state_e        state;
    logic [OFF_W-1:0] nxt_off;
    logic [NUM_W-1:0] num_q;
    logic             full, accept, store;
    logic             unused_msg_hi;

    assign unused_msg_hi = ^msg_data[REG_W-1:NUM_W];

    assign nxt_off   = (wr_off + OFF_W'(ENT_BYTES)) & ring_mask(cfg.size_sel);
    assign full      = cfg.full_chk && (nxt_off == rd_off);
    assign msg_ready = (state == ST_IDLE) && !(cfg.run && full && cfg.stop_full);
    assign accept    = msg_valid && msg_ready;
    assign store     = accept && cfg.run && !full;
    assign ovf_set   = accept && cfg.run && full;
    assign mem_valid = (state == ST_BUSY);
    assign mem_data  = make_entry(num_q);
    assign irq       = cfg.run && cfg.irq_on && (wr_off != rd_off);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            wr_off   <= '0;
            num_q    <= '0;
            mem_addr <= '0;
        end else begin
            case (state)
                ST_IDLE: if (store) begin
                    num_q    <= msg_data[NUM_W-1:0];
                    mem_addr <= base + BASE_W'(wr_off);
                    state    <= ST_BUSY;
                end
                ST_BUSY: if (mem_ready) begin
                    wr_off <= nxt_off;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R5: request held steady until taken
    a_r5_req_hold: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

    // R6: write offset stays entry aligned
    a_r6_wroff_aligned: assert property (@(posedge clk) disable iff (rst)
        wr_off[ENT_LOG2-1:0] == '0);

    // R6: write offset moves only after a memory handshake
    a_r6_adv_after_accept: assert property (@(posedge clk) disable iff (rst)
        wr_off != $past(wr_off) |-> $past(mem_valid && mem_ready));
endmodule

// File: rtl/msi_ring_writer.sv
`timescale 1ns/1ps
module msi_ring_writer
    import msi_ring_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wen,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              msg_valid,
    output logic              msg_ready,
    input  logic [REG_W-1:0]  msg_data,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [BASE_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              irq
);
    ring_cfg_t         cfg;
    logic [BASE_W-1:0] base;
    logic [OFF_W-1:0]  rd_off, wr_off;
    logic              ovf_set;

    msi_ring_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wen   (reg_wen),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .wr_off    (wr_off),
        .ovf_set   (ovf_set),
        .cfg       (cfg),
        .base      (base),
        .rd_off    (rd_off)
    );

    msi_ring_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .base      (base),
        .rd_off    (rd_off),
        .msg_valid (msg_valid),
        .msg_ready (msg_ready),
        .msg_data  (msg_data),
        .mem_valid (mem_valid),
        .mem_ready (mem_ready),
        .mem_addr  (mem_addr),
        .mem_data  (mem_data),
        .wr_off    (wr_off),
        .ovf_set   (ovf_set),
        .irq       (irq)
    );
endmodule

// File: tb/test_msi_ring_writer.sv
`timescale 1ns/1ps
module test_msi_ring_writer;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [2:0]   reg_addr = '0;
    logic         reg_wen = 1'b0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         msg_valid = 1'b0;
    logic         msg_ready;
    logic [31:0]  msg_data = '0;
    logic         mem_valid;
    logic         mem_ready = 1'b0;
    logic [63:0]  mem_addr;
    logic [127:0] mem_data;
    logic         irq;

    int n_tests = 0;
    int n_fail  = 0;

    bit         m_run, m_fc, m_ie, m_stop, m_ovf;
    bit [1:0]   m_sel;
    bit [63:0]  m_base;
    bit [17:0]  m_roff, m_woff;

    always #2 clk = ~clk;

    msi_ring_writer i_msi_ring_writer (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wen(reg_wen),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_data(msg_data), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data), .irq(irq)
    );

    task automatic check(input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit [17:0] m_mask(input bit [1:0] sel);
        return 18'(((32'd1 << (15 + int'(sel))) - 32'd1) & 32'hFFFF_FFF0);
    endfunction

    function automatic bit [17:0] m_next(input bit [17:0] w);
        return (w + 18'd16) & m_mask(m_sel);
    endfunction

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic set_ctrl(input bit run, input bit fc, input bit ie,
                            input bit stop, input bit [1:0] sel, input bit clr);
        logic [31:0] w;
        w = '0;
        w[0] = run; w[1] = fc; w[3] = ie; w[4] = stop; w[9:8] = sel; w[16] = clr;
        reg_wr(3'd0, w);
        m_run = run; m_fc = fc; m_ie = ie; m_stop = stop; m_sel = sel;
        if (clr) m_ovf = 1'b0;
    endtask

    task automatic set_roff(input logic [31:0] v);
        reg_wr(3'd5, v);
        m_roff = v[17:0] & m_mask(m_sel);
    endtask

    task automatic check_irq(input string req);
        #1;
        check(req, "irq", irq, m_run && m_ie && (m_woff != m_roff));
    endtask

    task automatic check_woff(input string req);
        logic [31:0] d;
        reg_rd(3'd6, d);
        check(req, "write offset", d, {14'd0, m_woff});
    endtask

    task automatic msg_step(input logic [31:0] d, input int lat);
        bit full, acc;
        full = m_fc && (m_next(m_woff) == m_roff);
        @(negedge clk);
        msg_valid = 1'b1; msg_data = d;
        #1;
        acc = msg_ready;
        check("R8", "msg_ready", acc, !(m_run && full && m_stop));
        if (!acc) begin
            for (int i = 0; i < 3; i++) begin
                @(negedge clk); #1;
                check("R8", "msg_ready held low", msg_ready, 1'b0);
            end
            msg_valid = 1'b0;
            check("R8", "no write while stalled", mem_valid, 1'b0);
            return;
        end
        @(negedge clk);
        msg_valid = 1'b0;
        #1;
        if (!m_run) begin
            check("R7", "mem_valid disabled", mem_valid, 1'b0);
            return;
        end
        if (full) begin
            check("R9", "mem_valid on drop", mem_valid, 1'b0);
            m_ovf = 1'b1;
            return;
        end
        for (int i = 0; i < lat; i++) begin
            check("R5", "mem_valid waiting", mem_valid, 1'b1);
            check("R5", "addr held", mem_addr, m_base + 64'(m_woff));
            check("R5", "msg_ready busy", msg_ready, 1'b0);
            @(negedge clk); #1;
        end
        check("R4", "mem_valid", mem_valid, 1'b1);
        check("R4", "mem_addr", mem_addr, m_base + 64'(m_woff));
        check("R4", "mem_data", mem_data, {112'd0, d[15:0]});
        mem_ready = 1'b1;
        @(negedge clk);
        mem_ready = 1'b0;
        m_woff = m_next(m_woff);
        #1;
        check("R5", "mem_valid after accept", mem_valid, 1'b0);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic [17:0] w0;
        void'($urandom(32'd2024));
        m_run = 0; m_fc = 0; m_ie = 0; m_stop = 0; m_ovf = 0; m_sel = 0;
        m_base = '0; m_roff = '0; m_woff = '0;

        repeat (3) @(negedge clk);
        #1;
        check("R1", "irq in reset", irq, 1'b0);
        check("R1", "mem_valid in reset", mem_valid, 1'b0);
        @(negedge clk); rst = 1'b0;
        reg_rd(3'd0, d); check("R1", "ctrl", d, 32'd0);
        reg_rd(3'd3, d); check("R1", "base hi", d, 32'd0);
        reg_rd(3'd4, d); check("R1", "base lo", d, 32'd0);
        reg_rd(3'd5, d); check("R1", "read offset", d, 32'd0);
        reg_rd(3'd6, d); check("R1", "write offset", d, 32'd0);

        // R2 register map
        reg_wr(3'd3, 32'hDEAD_BEEF); reg_rd(3'd3, d); check("R2", "base hi", d, 32'hDEAD_BEEF);
        reg_wr(3'd4, 32'h1234_5670); reg_rd(3'd4, d); check("R2", "base lo", d, 32'h1234_5670);
        m_base = 64'hDEAD_BEEF_1234_5670;
        reg_wr(3'd6, 32'h100); reg_rd(3'd6, d); check("R2", "write offset ignored", d, 32'd0);
        reg_rd(3'd1, d); check("R2", "addr 1", d, 32'd0);
        reg_rd(3'd2, d); check("R2", "addr 2", d, 32'd0);
        reg_rd(3'd7, d); check("R2", "addr 7", d, 32'd0);
        reg_wr(3'd0, 32'h0000_031B); reg_rd(3'd0, d); check("R2", "ctrl readback", d, 32'h0000_031B);

        // R3 read offset masking
        set_ctrl(0, 0, 0, 0, 2'd0, 0);
        reg_wr(3'd5, 32'hFFFF_FFFF); reg_rd(3'd5, d); check("R3", "mask 32K", d, 32'h0000_7FF0);
        set_ctrl(0, 0, 0, 0, 2'd2, 0);
        reg_wr(3'd5, 32'h0001_2345); reg_rd(3'd5, d); check("R3", "mask 128K", d, 32'h0001_2340);
        set_ctrl(0, 0, 0, 0, 2'd0, 0);
        set_roff(32'd0);

        // R7 disabled capture
        msg_step(32'h0000_0042, 0);
        check_woff("R7");

        // main function with random latencies
        set_ctrl(1, 1, 1, 0, 2'd0, 0);
        check_irq("R11");
        for (int i = 0; i < 6; i++) begin
            msg_step($urandom, int'($urandom % 4));
            check_irq("R11");
        end
        check_woff("R6");
        set_roff({14'd0, m_woff});
        check_irq("R11");
        msg_step(32'hFFFF_ABCD, 1);
        set_ctrl(1, 1, 0, 0, 2'd0, 0);
        check_irq("R11");

        // fill the 32 KB ring, crossing the wrap point
        set_ctrl(1, 1, 1, 1, 2'd0, 0);
        set_roff({14'd0, m_woff});
        for (int i = 0; i < 2047; i++) msg_step($urandom, int'($urandom % 3));
        check_woff("R6");
        check("R6", "one short of read offset", m_next(m_woff), m_roff);
        msg_step(32'h0000_1111, 0);   // stall (R8)
        check_woff("R8");

        set_ctrl(1, 1, 1, 0, 2'd0, 0);
        msg_step(32'h0000_2222, 0);   // drop (R9)
        check_woff("R9");
        reg_rd(3'd0, d); check("R9", "overflow set", d[16], 1'b1);
        set_ctrl(1, 1, 1, 0, 2'd0, 0);
        reg_rd(3'd0, d); check("R9", "overflow sticky", d[16], 1'b1);
        set_ctrl(1, 1, 1, 0, 2'd0, 1);
        reg_rd(3'd0, d); check("R9", "overflow cleared", d[16], 1'b0);

        set_ctrl(1, 0, 1, 0, 2'd0, 0);
        msg_step(32'h0000_3333, 2);   // no full check (R10)
        check("R10", "write equals read", m_woff, m_roff);
        check_woff("R10");
        check_irq("R10");

        // random mix on the 64 KB ring
        set_ctrl(1, 1, 1, 0, 2'd1, 0);
        for (int i = 0; i < 300; i++) begin
            int r;
            r = int'($urandom % 10);
            if (r == 0) set_roff($urandom);
            else if (r == 1) set_ctrl(($urandom % 5) != 0, $urandom % 2, $urandom % 2,
                                      $urandom % 2, 2'd1, ($urandom % 4) == 0);
            else msg_step($urandom, int'($urandom % 4));
            check_irq("R11");
        end
        check_woff("R6");
        reg_rd(3'd0, d); check("R9", "overflow after mix", d[16], m_ovf);

        // full lap of the 64 KB ring
        set_ctrl(1, 0, 1, 0, 2'd1, 0);
        w0 = m_woff;
        for (int i = 0; i < 4096; i++) msg_step($urandom, 0);
        check("R6", "lap model", m_woff, w0);
        check_woff("R6");

        finish_run();
    end
endmodule